// File: doc/BRIEF.md
# Peripheral Pad Ownership Controller with Sleep Override

This block sits between a bank of 22 peripheral pads and the on-chip units that normally drive them: three serial ports, each with independently enabled transmit and receive halves, a display controller, and a dedicated pair of pads for a differential bus transceiver. When a unit, or one half of a serial port, is disabled, its pads stop following the peripheral. They then act as plain general-purpose I/O, with a direction and an output level that software sets through a small register bus. Software can also read every pad's synchronized level, whichever side owns the pad.

A separate sleep-direction register has no reset. While the sleep indication is high it takes over every pad: a pad marked for output is driven low, and any other pad is released as an input. This override wins over both the peripheral reset that sleep entry applies and the system reset. As a result, pads that must not float keep a defined level for the whole sleep period.

Register addresses: 0 is direction (1 = output), 1 is output level, 2 is pad state (read-only), and 3 is sleep direction (1 = drive low during sleep). Each register holds one bit per pad.

Top module: `padctl_top`

## Requirements
- R1: After a synchronous reset, the direction and output-level registers read 0. Pads 2..21, with all enables low, have pad_oe low.
- R2: A pad whose owning enable is high copies per_out/per_oe to pad_out/pad_oe on the next clock edge.
- R3: A pad whose owning enable is low takes pad_oe from its direction bit and pad_out from its level bit, one edge after those registers change.
- R4: Ownership map: pads 0-1 are dedicated. Pad 2+2k follows unit_en[2k] (transmit half of port k) and pad 3+2k follows unit_en[2k+1] (receive half), for k = 0..2. Pads 8..21 follow unit_en[6] (display).
- R5: Pads 0 and 1 always follow per_out/per_oe outside sleep, independent of every enable.
- R6: Reading address 2 returns pad_in through two synchronizing flops. A change on pad_in appears in bus_rdata on the third clock edge, and not on the second.
- R7: While sleep_req is high, one edge later, pad_out is all 0 and pad_oe equals the sleep-direction register, regardless of enables, direction or peripheral signals.
- R8: The sleep-direction register keeps its value through rst. When rst and sleep_req are high together, the sleep override still drives the pads.
- R9: While sleep_req is high, the direction and level registers are held at 0 and writes to them are ignored. Writes to the sleep-direction register still take effect.
- R10: On the first edge that samples sleep_req low, the pads return to normal ownership using the current enables and registers.
- R11: bus_rdata is registered: it shows the addressed register one edge after bus_addr is presented. Writes to address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 dir, 1 level, 2 state, 3 sleep dir) |
| bus_wdata | input | 22 | Write data, one bit per pad |
| bus_rdata | output | 22 | Registered read data |
| unit_en | input | 7 | Unit enables: serial halves 0..5, display 6 |
| per_out | input | 22 | Peripheral drive level per pad |
| per_oe | input | 22 | Peripheral output enable per pad |
| pad_in | input | 22 | Pad input levels (asynchronous) |
| pad_out | output | 22 | Registered pad drive level |
| pad_oe | output | 22 | Registered pad output enable |
| sleep_req | input | 1 | Sleep indication |

## Verification
The pad outputs are registered, so the timing of each result depends on its source. An enable, peripheral-signal or sleep change is due at the first edge after it is applied. A register write shows at the pads one edge after the write edge. A pad_in change reaches bus_rdata on the third edge. The bench sets its inputs on the falling edge and samples exactly one rising edge after the last register on each path has loaded. For the synchronizer it also samples one edge early, to confirm that the new value is not yet visible. Table vectors are written through the bus and then checked after that extra edge.

// File: rtl/padctl_pkg.sv
package padctl_pkg;
  typedef enum logic [1:0] {
    A_DIR   = 2'd0,
    A_LVL   = 2'd1,
    A_STATE = 2'd2,
    A_SDIR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/padctl_sync.sv
module padctl_sync #(
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid <= '0;
      q   <= '0;
    end else begin
      mid <= d;
      q   <= mid;
    end
  end

  // R6: second stage carries what the first stage held one cycle before
  p_sync_chain_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q == $past(mid));
endmodule

// File: rtl/padctl_regs.sv
module padctl_regs
  import padctl_pkg::*;
#(
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] state,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] sdir_q,
  output logic [WIDTH-1:0] rdata
);
  reg_addr_e a;
  assign a = reg_addr_e'(addr);

  // direction and level: cleared by system reset and by sleep-entry reset
  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (wr) begin
      if (a == A_DIR) dir_q <= wdata;
      if (a == A_LVL) lvl_q <= wdata;
    end
  end

  // sleep direction: deliberately without reset
  always_ff @(posedge clk) begin
    if (wr && a == A_SDIR) sdir_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (a)
        A_DIR:   rdata <= dir_q;
        A_LVL:   rdata <= lvl_q;
        A_STATE: rdata <= state;
        default: rdata <= sdir_q;
      endcase
    end
  end

  // R9: sleep holds the normal registers cleared
  p_sleep_clears_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (dir_q == '0) && (lvl_q == '0));

  // R8: sleep direction only moves on its own write
  p_sdir_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == 2'd3) |=> $stable(sdir_q));

  // R11: address 2 write leaves direction and level alone
  p_state_ro_r11: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd2 && !sleep) |=> $stable(dir_q) && $stable(lvl_q));
endmodule

// File: rtl/padctl_mux.sv
module padctl_mux #(
  parameter int WIDTH     = 22,
  parameter int DED_PINS  = 2,
  parameter int SER_PORTS = 3,
  localparam int NUM_EN   = 2 * SER_PORTS + 1,
  localparam int SER_END  = DED_PINS + 2 * SER_PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [NUM_EN-1:0] unit_en,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  lvl_q,
  input  logic [WIDTH-1:0]  sdir_q,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  per_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  logic [WIDTH-1:0] own;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < DED_PINS) begin : g_ded
      assign own[i] = 1'b1;
      // R5: dedicated pads follow the peripheral outside sleep
      p_ded_follow_r5: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> pad_oe[i] == $past(per_oe[i]) && pad_out[i] == $past(per_out[i]));
    end else if (i < SER_END) begin : g_ser
      assign own[i] = unit_en[i - DED_PINS];
    end else begin : g_disp
      assign own[i] = unit_en[NUM_EN-1];
    end

    // R2: owned pads mirror the peripheral one edge later
    p_owned_r2: assert property (@(posedge clk) disable iff (rst)
      (!sleep && own[i]) |=> pad_out[i] == $past(per_out[i]) && pad_oe[i] == $past(per_oe[i]));
    // R3: released pads follow software direction and level
    p_free_r3: assert property (@(posedge clk) disable iff (rst)
      (!sleep && !own[i]) |=> pad_out[i] == $past(lvl_q[i]) && pad_oe[i] == $past(dir_q[i]));
  end

  always_ff @(posedge clk) begin
    if (sleep) begin
      pad_oe  <= sdir_q;
      pad_out <= '0;
    end else if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= (own & per_oe)  | (~own & dir_q);
      pad_out <= (own & per_out) | (~own & lvl_q);
    end
  end

  // R7: sleep drives low and applies the sleep direction
  p_sleep_low_r7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> pad_out == '0);
  p_sleep_oe_r7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> pad_oe == $past(sdir_q));
endmodule

// File: rtl/padctl_top.sv
module padctl_top #(
  parameter int NUM_PINS  = 22,
  parameter int DED_PINS  = 2,
  parameter int SER_PORTS = 3,
  localparam int NUM_EN   = 2 * SER_PORTS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_EN-1:0]   unit_en,
  input  logic [NUM_PINS-1:0] per_out,
  input  logic [NUM_PINS-1:0] per_oe,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic                sleep_req
);
  logic [NUM_PINS-1:0] state_s, dir_q, lvl_q, sdir_q;

  padctl_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(state_s)
  );

  padctl_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .sleep(sleep_req), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .state(state_s), .dir_q(dir_q), .lvl_q(lvl_q),
    .sdir_q(sdir_q), .rdata(bus_rdata)
  );

  padctl_mux #(.WIDTH(NUM_PINS), .DED_PINS(DED_PINS), .SER_PORTS(SER_PORTS)) u_mux (
    .clk(clk), .rst(rst), .sleep(sleep_req), .unit_en(unit_en),
    .dir_q(dir_q), .lvl_q(lvl_q), .sdir_q(sdir_q),
    .per_out(per_out), .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/padctl_top_bench.sv
`timescale 1ns/1ps
module padctl_top_bench;
  localparam int N  = 22;
  localparam int NE = 7;
  localparam int VW = NE + 4 * N;

  logic clk = 1'b0;
  logic rst, bus_wr, sleep_req;
  logic [1:0] bus_addr;
  logic [N-1:0] bus_wdata, bus_rdata, per_out, per_oe, pad_in, pad_out, pad_oe;
  logic [NE-1:0] unit_en;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  padctl_top u_padctl_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unit_en(unit_en),
    .per_out(per_out), .per_oe(per_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .sleep_req(sleep_req)
  );

  // {unit_en, dir, level, per_out, per_oe}
  localparam logic [VW-1:0] VECS [6] = '{
    {7'h00, 22'h3FFFFF, 22'h2AAAAA, 22'h155555, 22'h3FFFFF},
    {7'h7F, 22'h3FFFFF, 22'h000000, 22'h3C3C3C, 22'h0F0F0F},
    {7'h01, 22'h0000F0, 22'h3FFFFF, 22'h000004, 22'h000004},
    {7'h2A, 22'h155555, 22'h0F0F0F, 22'h3FFFFF, 22'h2AAAAA},
    {7'h40, 22'h00000C, 22'h000008, 22'h3FFF00, 22'h3FC000},
    {7'h15, 22'h3FFFFF, 22'h3FFFFF, 22'h000000, 22'h000000}
  };

  // R4 ownership map from the requirement text
  function automatic logic owned(input int p, input logic [NE-1:0] en);
    if (p < 2) return 1'b1;
    if (p < 8) return en[p-2];
    return en[6];
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] r, eo, ee, sd;
    rst = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    unit_en = '0; per_out = '0; per_oe = '0; pad_in = '0; sleep_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pad_oe in reset", pad_oe, '0);
    rst = 1'b0;
    wr(2'd3, 22'h000000);
    rd(2'd0, r); check("R1 dir after reset", r, '0);
    rd(2'd1, r); check("R1 level after reset", r, '0);
    check("R1 released pads input", pad_oe & 22'h3FFFFC, '0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 6; v++) begin
      logic [NE-1:0] en; logic [N-1:0] vd, vl, po, pe;
      {en, vd, vl, po, pe} = VECS[v];
      @(negedge clk);
      unit_en = en; per_out = po; per_oe = pe;
      wr(2'd0, vd);
      wr(2'd1, vl);
      @(posedge clk); @(negedge clk);
      for (int p = 0; p < N; p++) begin
        eo[p] = owned(p, en) ? po[p] : vl[p];
        ee[p] = owned(p, en) ? pe[p] : vd[p];
      end
      check($sformatf("R2/R3/R4 vec%0d pad_out", v), pad_out, eo);
      check($sformatf("R2/R3/R4 vec%0d pad_oe", v), pad_oe, ee);
      check($sformatf("R5 vec%0d dedicated", v), pad_oe & 22'h3, pe & 22'h3);
    end

    // R6 synchronizer latency
    @(negedge clk);
    pad_in = 22'h0F00F0; bus_addr = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 settled state", bus_rdata, 22'h0F00F0);
    pad_in = 22'h3A5A5A;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 not yet after two edges", bus_rdata, 22'h0F00F0);
    @(posedge clk); @(negedge clk);
    check("R6 visible on third edge", bus_rdata, 22'h3A5A5A);

    // R11 write to state address ignored
    wr(2'd0, 22'h00ABCD);
    wr(2'd2, 22'h3FFFFF);
    rd(2'd2, r); check("R11 state unaffected", r, 22'h3A5A5A);
    rd(2'd0, r); check("R11 dir unaffected", r, 22'h00ABCD);

    // R7 sleep override
    sd = 22'h2C3A05;
    wr(2'd3, sd);
    wr(2'd0, 22'h3FFFFF);
    wr(2'd1, 22'h3FFFFF);
    @(negedge clk);
    unit_en = 7'h7F; per_out = 22'h3FFFFF; per_oe = 22'h3FFFFF; sleep_req = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 sleep oe", pad_oe, sd);
    check("R7 sleep drives low", pad_out, '0);

    // R9 normal registers cleared and locked, sleep dir writable
    rd(2'd0, r); check("R9 dir cleared in sleep", r, '0);
    wr(2'd1, 22'h123456);
    rd(2'd1, r); check("R9 level write ignored", r, '0);
    sd = 22'h0F0F0F;
    wr(2'd3, sd);
    @(posedge clk); @(negedge clk);
    check("R9 sleep dir write applies", pad_oe, sd);

    // R8 survives reset, and sleep beats reset
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 sleep wins over reset", pad_oe, sd);
    check("R8 pads low under reset", pad_out, '0);
    sleep_req = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    rd(2'd3, r); check("R8 sleep dir kept through reset", r, sd);

    // R10 exit to normal ownership on first edge
    @(negedge clk);
    sleep_req = 1'b1; unit_en = 7'h40; per_out = 22'h3FFF00; per_oe = 22'h3FFF03;
    @(posedge clk); @(negedge clk);
    check("R10 in sleep", pad_oe, sd);
    sleep_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 exit oe", pad_oe, 22'h3FFF03);
    check("R10 exit out", pad_out, 22'h3FFF00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule